// File: doc/BRIEF.md
# Pointer-Addressed Configuration Window with Keyed Soft Reset

This block is the register-access front end of a two-wire bus controller. A host reaches it through a narrow synchronous parallel port with four direct locations. One location holds an index register. The second location is a data window that reads and writes whichever internal configuration register the index selects. The two remaining direct locations read as zero and ignore writes.

The internal registers are the controller's own bus address, a timeout count, a two-bit speed class, and the clock low-phase and high-phase counts. The values of these registers drive the controller core continuously. One further index is a write-only key entry. When the host writes the byte 0xA5 and then the byte 0x5A through the window while the index points at this entry, the block raises a single-cycle soft-reset pulse to the core. Any other write, or any index change, cancels a half-entered key.

Top module: `cfg_window_top`

## Requirements
- R1: After reset the index is 0x00, rdata is 0x00 and soft_rst is low. The configuration outputs reset to own_addr 0x00, timeout 0x00, speed_mode 2'b00, scl_low 0x9D and scl_high 0x86.
- R2: A write to direct address 0 loads all 8 bits into the index. A read of direct address 0 returns the index.
- R3: A write to direct address 1 updates the register the index selects: 0 own address, 1 timeout, 2 speed class, 3 low count, 4 high count. The new value appears on the matching output one cycle after the write and reads back through address 1.
- R4: The own-address value reads back unchanged after writes to other indexed registers.
- R5: The speed class keeps only wdata[1:0] (00 standard, 01 fast, 10 fast-plus, 11 turbo). It reads back with bits 7:2 as zero.
- R6: Index values 6 to 255 read as 0x00 through the window, and window writes to them change no output.
- R7: The key entry (index 5) reads as 0x00. A window write of 0xA5 followed directly by a window write of 0x5A at that index gives soft_rst high for exactly the one cycle after the 0x5A write.
- R8: After an accepted 0xA5, a window write of any value other than 0x5A cancels the key, so a following 0x5A gives no pulse.
- R9: Any write to the index (address 0) cancels a half-entered key.
- R10: A 0x5A without a preceding accepted 0xA5 gives no pulse. After a pulse the detector starts from its cleared state.
- R11: rdata is registered. It takes the value of the location accessed one cycle after a read with cs and re high, and holds otherwise. Direct addresses 2 and 3 read 0x00, and writes to them change nothing.
- R12: When a write and a read to the same location occur in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select for one host access |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| addr | input | 2 | Direct location: 0 index, 1 window, 2 and 3 unused |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| soft_rst | output | 1 | One-cycle soft-reset pulse to the core |
| own_addr | output | 8 | Own bus address |
| timeout | output | 8 | Timeout count |
| speed_mode | output | 2 | Speed class |
| scl_low | output | 8 | Clock low-phase count |
| scl_high | output | 8 | Clock high-phase count |

## Verification
A single host cycle can both write and read. The write updates the index or a register, or it completes the key and fires soft_rst. In that same cycle the read captures a value into rdata. The bench issues combined write-plus-read accesses to the index, to configuration registers and to the key entry, including the 0x5A that completes the key. It then checks that rdata holds the value from before the write, and that the pulse and the register update still happen as a plain write would cause them.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;

    localparam int DW = 8;
    localparam int AW = 2;
    localparam int MODE_W = 2;

    localparam logic [AW-1:0] LOC_INDEX  = 2'd0;
    localparam logic [AW-1:0] LOC_WINDOW = 2'd1;

    localparam logic [DW-1:0] KEY_FIRST  = 8'hA5;
    localparam logic [DW-1:0] KEY_SECOND = 8'h5A;

    typedef enum logic [2:0] {
        SEL_OWN  = 3'd0,
        SEL_TMO  = 3'd1,
        SEL_MODE = 3'd2,
        SEL_LOW  = 3'd3,
        SEL_HIGH = 3'd4,
        SEL_KEY  = 3'd5,
        SEL_NONE = 3'd6
    } reg_sel_e;

    typedef enum logic [MODE_W-1:0] {
        SPD_STANDARD = 2'b00,
        SPD_FAST     = 2'b01,
        SPD_FASTPLUS = 2'b10,
        SPD_TURBO    = 2'b11
    } speed_e;

    typedef struct packed {
        logic [DW-1:0] own;
        logic [DW-1:0] tmo;
        speed_e        mode;
        logic [DW-1:0] low;
        logic [DW-1:0] high;
    } cfg_t;

    function automatic reg_sel_e decode_index(input logic [DW-1:0] idx);
        reg_sel_e s;
        case (idx)
            8'd0:    s = SEL_OWN;
            8'd1:    s = SEL_TMO;
            8'd2:    s = SEL_MODE;
            8'd3:    s = SEL_LOW;
            8'd4:    s = SEL_HIGH;
            8'd5:    s = SEL_KEY;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cfg_index_decode.sv
module cfg_index_decode
    import cfg_window_pkg::*;
(
    input  logic [DW-1:0] idx,
    output reg_sel_e      sel
);
    always_comb sel = decode_index(idx);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_window_pkg::*;
#(
    parameter logic [DW-1:0] OWN_INIT  = 8'h00,
    parameter logic [DW-1:0] TMO_INIT  = 8'h00,
    parameter logic [DW-1:0] LOW_INIT  = 8'h9D,
    parameter logic [DW-1:0] HIGH_INIT = 8'h86
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.own  <= OWN_INIT;
            cfg.tmo  <= TMO_INIT;
            cfg.mode <= SPD_STANDARD;
            cfg.low  <= LOW_INIT;
            cfg.high <= HIGH_INIT;
        end else if (wr_en) begin
            case (sel)
                SEL_OWN:  cfg.own  <= wdata;
                SEL_TMO:  cfg.tmo  <= wdata;
                SEL_MODE: cfg.mode <= speed_e'(wdata[MODE_W-1:0]);
                SEL_LOW:  cfg.low  <= wdata;
                SEL_HIGH: cfg.high <= wdata;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_key_detect.sv
module cfg_key_detect
    import cfg_window_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          win_wr,
    input  logic          idx_wr,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    output logic          pulse
);
    logic armed_q;
    logic key_wr;

    assign key_wr = win_wr && (sel == SEL_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            pulse   <= 1'b0;
        end else begin
            pulse <= key_wr && armed_q && (wdata == KEY_SECOND);
            if (idx_wr) begin
                armed_q <= 1'b0;
            end else if (key_wr) begin
                armed_q <= !armed_q && (wdata == KEY_FIRST);
            end
        end
    end
endmodule

// File: rtl/cfg_window_top.sv
module cfg_window_top
    import cfg_window_pkg::*;
#(
    parameter logic [7:0] OWN_INIT  = 8'h00,
    parameter logic [7:0] TMO_INIT  = 8'h00,
    parameter logic [7:0] LOW_INIT  = 8'h9D,
    parameter logic [7:0] HIGH_INIT = 8'h86
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs,
    input  logic       we,
    input  logic       re,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       soft_rst,
    output logic [7:0] own_addr,
    output logic [7:0] timeout,
    output logic [1:0] speed_mode,
    output logic [7:0] scl_low,
    output logic [7:0] scl_high
);
    logic [DW-1:0] idx_q;
    reg_sel_e      sel;
    cfg_t          cfg;
    logic          idx_wr, win_wr, rd_en;
    logic [DW-1:0] rd_mux;

    assign idx_wr = cs && we && (addr == LOC_INDEX);
    assign win_wr = cs && we && (addr == LOC_WINDOW);
    assign rd_en  = cs && re;

    always_ff @(posedge clk) begin
        if (rst)         idx_q <= '0;
        else if (idx_wr) idx_q <= wdata;
    end

    cfg_index_decode u_dec (.idx(idx_q), .sel(sel));

    cfg_reg_bank #(
        .OWN_INIT(OWN_INIT), .TMO_INIT(TMO_INIT),
        .LOW_INIT(LOW_INIT), .HIGH_INIT(HIGH_INIT)
    ) u_bank (
        .clk(clk), .rst(rst), .wr_en(win_wr), .sel(sel),
        .wdata(wdata), .cfg(cfg)
    );

    cfg_key_detect u_key (
        .clk(clk), .rst(rst), .win_wr(win_wr), .idx_wr(idx_wr),
        .sel(sel), .wdata(wdata), .pulse(soft_rst)
    );

    always_comb begin
        rd_mux = '0;
        if (addr == LOC_INDEX) begin
            rd_mux = idx_q;
        end else if (addr == LOC_WINDOW) begin
            case (sel)
                SEL_OWN:  rd_mux = cfg.own;
                SEL_TMO:  rd_mux = cfg.tmo;
                SEL_MODE: rd_mux = {{(DW-MODE_W){1'b0}}, cfg.mode};
                SEL_LOW:  rd_mux = cfg.low;
                SEL_HIGH: rd_mux = cfg.high;
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign own_addr   = cfg.own;
    assign timeout    = cfg.tmo;
    assign speed_mode = cfg.mode;
    assign scl_low    = cfg.low;
    assign scl_high   = cfg.high;
endmodule

// File: rtl/cfg_window_checker.sv
module cfg_window_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs,
    input logic       we,
    input logic       re,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       soft_rst,
    input logic [7:0] own_addr,
    input logic [7:0] timeout,
    input logic [1:0] speed_mode,
    input logic [7:0] scl_low,
    input logic [7:0] scl_high,
    input logic [7:0] idx
);
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !soft_rst); // R7

    AST_PULSE_NEEDS_SECOND_KEY: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> $past(cs && we && addr == 2'd1 && wdata == 8'h5A && idx == 8'd5)); // R7

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(cs && re) |=> $stable(rdata)); // R11

    AST_UNUSED_LOC_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cs && we && addr[1]) |=> ($stable(own_addr) && $stable(timeout) && $stable(speed_mode)
            && $stable(scl_low) && $stable(scl_high) && $stable(idx))); // R11

    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cs && re && addr == 2'd1 && idx >= 8'd5) |=> (rdata == 8'h00)); // R6

    AST_UNMAPPED_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (cs && we && addr == 2'd1 && idx >= 8'd5) |=> ($stable(own_addr) && $stable(timeout)
            && $stable(speed_mode) && $stable(scl_low) && $stable(scl_high))); // R6

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cs && we && addr == 2'd0) |=> (idx == $past(wdata))); // R2
endmodule

bind cfg_window_top cfg_window_checker i_chk (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .re(re), .addr(addr), .wdata(wdata),
    .rdata(rdata), .soft_rst(soft_rst), .own_addr(own_addr), .timeout(timeout),
    .speed_mode(speed_mode), .scl_low(scl_low), .scl_high(scl_high), .idx(idx_q)
);

// File: tb/test_cfg_window_top.sv
`timescale 1ns/1ps
module test_cfg_window_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0, we = 1'b0, re = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, own_addr, timeout, scl_low, scl_high;
    logic [1:0] speed_mode;
    logic soft_rst;

    int total = 0;
    int bad = 0;

    logic [7:0] m_idx, m_own, m_tmo, m_low, m_high;
    logic [1:0] m_mode;
    logic       m_armed;

    always #2.5 clk = ~clk;

    cfg_window_top i_cfg_window_top (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .re(re), .addr(addr), .wdata(wdata),
        .rdata(rdata), .soft_rst(soft_rst), .own_addr(own_addr), .timeout(timeout),
        .speed_mode(speed_mode), .scl_low(scl_low), .scl_high(scl_high)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_loc(input logic [1:0] a);
        if (a == 2'd0) return m_idx;
        if (a != 2'd1) return 8'h00;
        case (m_idx)
            8'd0: return m_own;
            8'd1: return m_tmo;
            8'd2: return {6'b0, m_mode};
            8'd3: return m_low;
            8'd4: return m_high;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_pulse(input logic [1:0] a, input logic [7:0] d);
        return (a == 2'd1) && (m_idx == 8'd5) && m_armed && (d == 8'h5A);
    endfunction

    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        if (a == 2'd0) begin
            m_idx = d; m_armed = 1'b0;
        end else if (a == 2'd1) begin
            case (m_idx)
                8'd0: m_own = d;
                8'd1: m_tmo = d;
                8'd2: m_mode = d[1:0];
                8'd3: m_low = d;
                8'd4: m_high = d;
                8'd5: m_armed = !m_armed && (d == 8'hA5);
                default: ;
            endcase
        end
    endtask

    task automatic check_outputs(input string req);
        check({req, " own_addr"}, own_addr, m_own);
        check({req, " timeout"}, timeout, m_tmo);
        check({req, " speed_mode"}, {6'b0, speed_mode}, {6'b0, m_mode});
        check({req, " scl_low"}, scl_low, m_low);
        check({req, " scl_high"}, scl_high, m_high);
    endtask

    // access with optional write and read in the same cycle (R12)
    task automatic access(input logic [1:0] a, input logic [7:0] d, input logic w,
                          input logic r, input string req);
        logic [7:0] old_val;
        logic       p;
        old_val = exp_loc(a);
        p = w && exp_pulse(a, d);
        @(negedge clk);
        cs = 1'b1; we = w; re = r; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0; re = 1'b0;
        if (w) model_write(a, d);
        if (r) check({req, " read"}, rdata, old_val);
        if (w) begin
            check({req, " soft_rst"}, {7'b0, soft_rst}, {7'b0, p});
            check_outputs(req);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string req);
        access(a, d, 1'b1, 1'b0, req);
    endtask

    task automatic rd(input logic [1:0] a, input string req);
        access(a, 8'h00, 1'b0, 1'b1, req);
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'd4711));
        m_idx = 0; m_own = 0; m_tmo = 0; m_low = 8'h9D; m_high = 8'h86;
        m_mode = 0; m_armed = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", rdata, 8'h00);
        check("R1 soft_rst", {7'b0, soft_rst}, 8'h00);
        check_outputs("R1");
        rd(2'd0, "R1 index");

        // R2 / R3 each register
        for (int i = 0; i < 5; i++) begin
            wr(2'd0, 8'(i), "R2");
            rd(2'd0, "R2");
            wr(2'd1, 8'(8'h31 + i * 8'h11), "R3");
            rd(2'd1, "R3");
        end
        // R4 own address survives other writes
        wr(2'd0, 8'd0, "R4"); wr(2'd1, 8'h6C, "R4");
        wr(2'd0, 8'd3, "R4"); wr(2'd1, 8'h22, "R4");
        wr(2'd0, 8'd1, "R4"); wr(2'd1, 8'h77, "R4");
        wr(2'd0, 8'd0, "R4"); rd(2'd1, "R4");
        check("R4 own", own_addr, 8'h6C);
        // R5 speed class keeps two bits
        wr(2'd0, 8'd2, "R5"); wr(2'd1, 8'hFE, "R5"); rd(2'd1, "R5");
        check("R5 mode", {6'b0, speed_mode}, 8'h02);
        wr(2'd1, 8'hC3, "R5"); rd(2'd1, "R5");
        // R6 unmapped indices
        wr(2'd0, 8'd6, "R6"); wr(2'd1, 8'hFF, "R6"); rd(2'd1, "R6");
        wr(2'd0, 8'hF0, "R6"); wr(2'd1, 8'h12, "R6"); rd(2'd1, "R6");
        // R11 direct locations 2 and 3
        wr(2'd2, 8'h44, "R11"); wr(2'd3, 8'h55, "R11");
        rd(2'd2, "R11"); rd(2'd3, "R11");
        held = rdata;
        repeat (3) @(negedge clk);
        check("R11 hold", rdata, held);
        // R7 key
        wr(2'd0, 8'd5, "R7"); rd(2'd1, "R7");
        wr(2'd1, 8'hA5, "R7"); wr(2'd1, 8'h5A, "R7");
        @(negedge clk);
        check("R7 pulse width", {7'b0, soft_rst}, 8'h00);
        // R10 5A after pulse and 5A alone
        wr(2'd1, 8'h5A, "R10"); wr(2'd1, 8'h5A, "R10");
        // R8 wrong byte cancels
        wr(2'd1, 8'hA5, "R8"); wr(2'd1, 8'h00, "R8"); wr(2'd1, 8'h5A, "R8");
        wr(2'd1, 8'hA5, "R8"); wr(2'd1, 8'hA5, "R8"); wr(2'd1, 8'h5A, "R8");
        // R9 index write cancels
        wr(2'd1, 8'hA5, "R9"); wr(2'd0, 8'd5, "R9"); wr(2'd1, 8'h5A, "R9");
        // R12 write and read in the same cycle
        access(2'd0, 8'd4, 1'b1, 1'b1, "R12 index");
        access(2'd1, 8'hE1, 1'b1, 1'b1, "R12 window");
        access(2'd0, 8'd5, 1'b1, 1'b1, "R12 key index");
        access(2'd1, 8'hA5, 1'b1, 1'b1, "R12 key first");
        access(2'd1, 8'h5A, 1'b1, 1'b1, "R12 key second");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int k;
            logic [7:0] d;
            k = int'($urandom_range(0, 9));
            d = 8'($urandom);
            if ($urandom_range(0, 3) == 0) d = ($urandom_range(0, 1) != 0) ? 8'hA5 : 8'h5A;
            if (k < 2)
                wr(2'd0, ($urandom_range(0, 4) == 0) ? d : 8'($urandom_range(0, 6)), "R3 random index");
            else if (k < 6)
                wr(2'd1, d, "R3 random window");
            else if (k < 9)
                rd(2'($urandom_range(0, 3)), "R11 random read");
            else
                access(2'($urandom_range(0, 3)), d, 1'b1, 1'b1, "R12 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule